// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets an on-chip requester read or write a single byte in an external asynchronous static RAM. The RAM has 18 address bits, 8 data bits, and two chip enables of opposite polarity. It also has an active-low write strobe and an active-low output strobe. The requester uses a valid/ready handshake. Each request carries an address, a write flag and write data. A read returns its byte with a one-cycle valid pulse.

The controller generates all RAM strobes from registers. The length of each phase is a whole number of clock cycles. That number is derived at elaboration time from a clock-period parameter and a speed-grade parameter. Each interval in nanoseconds is divided by the period and rounded up, with a floor of one cycle.

Between accesses the RAM is deselected, so it stays in its low-power standby. The bidirectional data bus appears as three separate signals: write data out, read data in, and an output enable for the pad.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Whenever the controller is idle (`req_ready` = 1), the RAM is deselected (`sram_ce_n` = 1). `sram_ce2` is always 1.
- R3: A read holds `sram_ce_n` and `sram_oe_n` low and `sram_we_n` high for exactly ceil(read_ns / CLK_NS) cycles, where read_ns is 55 for the fast grade. The value on `sram_dq_in` at the last of those edges is returned on `rsp_rdata`. `rsp_valid` is 1 for exactly one cycle, the first idle cycle after the read.
- R4: A write holds `sram_we_n` low for ceil(max(pulse_ns, setup_ns) / CLK_NS) cycles, where pulse_ns is 30 and setup_ns is 25 for the fast grade. `sram_dq_oe` is 1 from one cycle before `sram_we_n` falls until one cycle after it rises, which is two cycles more than the low time. `sram_ce_n` is low over the same span. `sram_oe_n` stays 1 for the whole write.
- R5: `sram_addr` changes only in a cycle in which `sram_we_n` is 1 and was also 1 in the previous cycle.
- R6: A write that does not follow a read keeps `req_ready` low for 2 + WE + max(1, ceil(wcycle_ns / CLK_NS) − WE − 2) cycles. WE is the write-enable low time from R4, and wcycle_ns is 55 for the fast grade. With the default 4 ns clock this is 14 cycles.
- R7: A write accepted when the previous access was a read first waits max(1, ceil(float_ns / CLK_NS)) extra cycles, with the RAM deselected and the bus not driven. float_ns is 25 for the fast grade. A write that follows a write waits no extra cycles. `sram_dq_oe` is never 1 while `sram_oe_n` is 0.
- R8: A request is accepted on the clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the edge that accepts a request until the access has finished.
- R9: With the slow grade the figures are 70 ns read and write cycles, a 35 ns write pulse, 30 ns data setup and 30 ns float time. With a 4 ns clock this gives 18 read cycles, 9 write-enable cycles, 18 write busy cycles and 8 turnaround cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | 8 | Read data |
| sram_addr | output | 18 | RAM address |
| sram_ce_n | output | 1 | RAM low-active chip enable |
| sram_ce2 | output | 1 | RAM high-active chip enable |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output strobe, active low |
| sram_dq_out | output | 8 | Data toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for the data pads |
| sram_dq_in | input | 8 | Data from the RAM |

## Verification
Writes and reads use all-zero, all-one and alternating data bytes. They go to the lowest address, the highest address and two middle addresses. A wrong byte or address lane therefore shows up as a mismatch on read-back. The order of accesses is varied: write after write, read after read, and read followed by write. This separates the turnaround path from the plain write path. A second instance built for the slow grade shows whether the cycle counts really follow the grade parameter.

// File: rtl/asram_ctrl_pkg.sv
`timescale 1ns/1ps
package asram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_WREC
    } phase_e;

    // Round a nanosecond interval up to clock cycles, never below one cycle.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/asram_timing.sv
`timescale 1ns/1ps
module asram_timing #(
    parameter int unsigned CLK_NS     = 4,
    parameter bit          FAST_GRADE = 1'b1,
    parameter int unsigned CNT_W      = 8
) (
    output logic [CNT_W-1:0] rd_cyc,
    output logic [CNT_W-1:0] we_cyc,
    output logic [CNT_W-1:0] rec_cyc,
    output logic [CNT_W-1:0] turn_cyc
);
    import asram_ctrl_pkg::*;

    localparam int unsigned RD_NS    = FAST_GRADE ? 55 : 70;
    localparam int unsigned WC_NS    = FAST_GRADE ? 55 : 70;
    localparam int unsigned PULSE_NS = FAST_GRADE ? 30 : 35;
    localparam int unsigned SETUP_NS = FAST_GRADE ? 25 : 30;
    localparam int unsigned FLOAT_NS = FAST_GRADE ? 25 : 30;

    localparam int unsigned RD_C   = ns_to_cyc(RD_NS, CLK_NS);
    localparam int unsigned WE_C   = ns_to_cyc((PULSE_NS > SETUP_NS) ? PULSE_NS : SETUP_NS, CLK_NS);
    localparam int unsigned WC_C   = ns_to_cyc(WC_NS, CLK_NS);
    localparam int unsigned REC_C  = (WC_C > WE_C + 3) ? (WC_C - WE_C - 2) : 1;
    localparam int unsigned TURN_C = ns_to_cyc(FLOAT_NS, CLK_NS);

    assign rd_cyc   = CNT_W'(RD_C);
    assign we_cyc   = CNT_W'(WE_C);
    assign rec_cyc  = CNT_W'(REC_C);
    assign turn_cyc = CNT_W'(TURN_C);

endmodule

// File: rtl/asram_phase_cnt.sv
`timescale 1ns/1ps
module asram_phase_cnt #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl #(
    parameter int unsigned CLK_NS     = 4,
    parameter bit          FAST_GRADE = 1'b1,
    parameter int unsigned ADDR_W     = 18,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_ce2,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    import asram_ctrl_pkg::*;

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic              last_rd;
    } ctl_t;

    localparam ctl_t CTL_RST = '{ph: ST_IDLE, addr: '0, wdata: '0, rdata: '0,
                                 rvalid: 1'b0, ce_n: 1'b1, we_n: 1'b1,
                                 oe_n: 1'b1, dq_oe: 1'b0, last_rd: 1'b0};

    ctl_t             c_d, c_q;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_done;
    logic [CNT_W-1:0] rd_cyc, we_cyc, rec_cyc, turn_cyc;

    asram_timing #(.CLK_NS(CLK_NS), .FAST_GRADE(FAST_GRADE), .CNT_W(CNT_W)) u_timing (
        .rd_cyc  (rd_cyc),
        .we_cyc  (we_cyc),
        .rec_cyc (rec_cyc),
        .turn_cyc(turn_cyc)
    );

    asram_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .done    (cnt_done)
    );

    always_comb begin
        c_d        = c_q;
        c_d.rvalid = 1'b0;
        cnt_load   = 1'b0;
        cnt_val    = '0;
        unique case (c_q.ph)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.addr  = req_addr;
                    c_d.wdata = req_wdata;
                    if (!req_write) begin
                        c_d.ph      = ST_READ;
                        c_d.ce_n    = 1'b0;
                        c_d.oe_n    = 1'b0;
                        c_d.last_rd = 1'b1;
                        cnt_load    = 1'b1;
                        cnt_val     = rd_cyc - CNT_W'(1);
                    end else if (c_q.last_rd) begin
                        c_d.ph      = ST_TURN;
                        c_d.last_rd = 1'b0;
                        cnt_load    = 1'b1;
                        cnt_val     = turn_cyc - CNT_W'(1);
                    end else begin
                        c_d.ph    = ST_WSETUP;
                        c_d.ce_n  = 1'b0;
                        c_d.dq_oe = 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (cnt_done) begin
                    c_d.ph     = ST_IDLE;
                    c_d.rdata  = sram_dq_in;
                    c_d.rvalid = 1'b1;
                    c_d.ce_n   = 1'b1;
                    c_d.oe_n   = 1'b1;
                end
            end
            ST_TURN: begin
                if (cnt_done) begin
                    c_d.ph    = ST_WSETUP;
                    c_d.ce_n  = 1'b0;
                    c_d.dq_oe = 1'b1;
                end
            end
            ST_WSETUP: begin
                c_d.ph   = ST_WPULSE;
                c_d.we_n = 1'b0;
                cnt_load = 1'b1;
                cnt_val  = we_cyc - CNT_W'(1);
            end
            ST_WPULSE: begin
                if (cnt_done) begin
                    c_d.ph   = ST_WHOLD;
                    c_d.we_n = 1'b1;
                end
            end
            ST_WHOLD: begin
                c_d.ph    = ST_WREC;
                c_d.dq_oe = 1'b0;
                c_d.ce_n  = 1'b1;
                cnt_load  = 1'b1;
                cnt_val   = rec_cyc - CNT_W'(1);
            end
            ST_WREC: begin
                if (cnt_done) c_d.ph = ST_IDLE;
            end
            default: c_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= CTL_RST;
        else        c_q <= c_d;
    end

    assign req_ready   = (c_q.ph == ST_IDLE);
    assign rsp_valid   = c_q.rvalid;
    assign rsp_rdata   = c_q.rdata;
    assign sram_addr   = c_q.addr;
    assign sram_ce_n   = c_q.ce_n;
    assign sram_ce2    = 1'b1;
    assign sram_we_n   = c_q.we_n;
    assign sram_oe_n   = c_q.oe_n;
    assign sram_dq_out = c_q.wdata;
    assign sram_dq_oe  = c_q.dq_oe;

    p_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> sram_ce_n);
    p_read_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (sram_we_n && !sram_ce_n));
    p_rvalid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_data_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> ($past(sram_dq_oe) && !sram_ce_n));
    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (sram_dq_oe && !sram_ce_n));
    p_write_no_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_oe_n && sram_dq_oe));
    p_addr_we_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sram_addr) |-> (sram_we_n && $past(sram_we_n)));
    p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);
    p_rvalid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

endmodule

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;

    function automatic int cdiv(input int a, input int b);
        int c;
        c = (a + b - 1) / b;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int T = 4;
    // fast grade
    localparam int F_RD   = cdiv(55, T);
    localparam int F_WE   = cdiv(30, T);
    localparam int F_WC   = cdiv(55, T);
    localparam int F_WBSY = 2 + F_WE + ((F_WC - F_WE - 2 > 1) ? F_WC - F_WE - 2 : 1);
    localparam int F_TURN = cdiv(25, T);
    // slow grade
    localparam int S_RD   = cdiv(70, T);
    localparam int S_WE   = cdiv(35, T);
    localparam int S_WC   = cdiv(70, T);
    localparam int S_WBSY = 2 + S_WE + ((S_WC - S_WE - 2 > 1) ? S_WC - S_WE - 2 : 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // fast instance signals
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rdy, rv;
    logic [7:0]  rdata;
    logic [17:0] addr;
    logic        ce_n, ce2, we_n, oe_n, dq_oe;
    logic [7:0]  dq_out, dq_in;

    asram_ctrl #(.CLK_NS(T), .FAST_GRADE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rv), .rsp_rdata(rdata), .sram_addr(addr), .sram_ce_n(ce_n),
        .sram_ce2(ce2), .sram_we_n(we_n), .sram_oe_n(oe_n), .sram_dq_out(dq_out),
        .sram_dq_oe(dq_oe), .sram_dq_in(dq_in));

    // slow instance signals
    logic        s_valid = 1'b0, s_write = 1'b0;
    logic [17:0] s_addr_req = '0;
    logic [7:0]  s_wdata = '0;
    logic        s_rdy, s_rv, s_ce_n, s_ce2, s_we_n, s_oe_n, s_dq_oe;
    logic [7:0]  s_rdata, s_dq_out;
    logic [17:0] s_addr;

    asram_ctrl #(.CLK_NS(T), .FAST_GRADE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(s_valid), .req_ready(s_rdy),
        .req_write(s_write), .req_addr(s_addr_req), .req_wdata(s_wdata),
        .rsp_valid(s_rv), .rsp_rdata(s_rdata), .sram_addr(s_addr), .sram_ce_n(s_ce_n),
        .sram_ce2(s_ce2), .sram_we_n(s_we_n), .sram_oe_n(s_oe_n), .sram_dq_out(s_dq_out),
        .sram_dq_oe(s_dq_oe), .sram_dq_in(8'h3C));

    // RAM model for the fast instance (low 8 address bits)
    logic [7:0] mem [0:255];
    logic       we_seen = 1'b1;
    initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    assign dq_in = (!ce_n && ce2 && we_n && !oe_n) ? mem[addr[7:0]] : 8'hEE;

    always @(negedge clk) begin
        if (!we_seen && we_n && !ce_n && dq_oe) mem[addr[7:0]] <= dq_out;
        we_seen <= we_n;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // continuous port monitors
    logic [17:0] addr_prev = '0;
    logic        we_prev = 1'b1, oe_prev_drv = 1'b0;
    int          oe_hi = 100;
    always @(negedge clk) begin
        if (rst_n) begin
            if (addr != addr_prev) chk("R5 addr change with we_n high", int'(we_n && we_prev), 1);
            if (dq_oe && !oe_n) chk("R7 bus contention", 1, 0);
            if (dq_oe && !oe_prev_drv) chk("R7 float gap before drive", int'(oe_hi >= F_TURN), 1);
        end
        addr_prev   <= addr;
        we_prev     <= we_n;
        oe_prev_drv <= dq_oe;
        oe_hi       <= oe_n ? ((oe_hi < 100) ? oe_hi + 1 : oe_hi) : 0;
    end

    int busy, we_lo, oe_lo, drv, ce_lo;
    logic [7:0] got;
    logic       got_v;

    task automatic run_u0(input logic wr, input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!rdy) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0; we_lo = 0; oe_lo = 0; drv = 0; ce_lo = 0;
        while (!rdy && busy < 1000) begin
            busy++;
            if (!we_n) we_lo++;
            if (!oe_n) oe_lo++;
            if (dq_oe) drv++;
            if (!ce_n) ce_lo++;
            @(negedge clk);
        end
        got = rdata; got_v = rv;
        chk("R2 deselected when idle", int'(ce_n), 1);
        @(negedge clk);
        chk("R3 rsp_valid single cycle", int'(rv), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 ce_n in reset", int'(ce_n), 1);
        chk("R1 we_n in reset", int'(we_n), 1);
        chk("R1 oe_n in reset", int'(oe_n), 1);
        chk("R1 dq_oe in reset", int'(dq_oe), 0);
        chk("R1 ready in reset", int'(rdy), 1);
        chk("R1 rsp_valid in reset", int'(rv), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", int'({ce_n, we_n, oe_n, dq_oe, rdy, rv}), 6'b111010);
    endtask

    task automatic t_standby;
        repeat (5) @(negedge clk);
        chk("R2 standby ce_n", int'(ce_n), 1);
        chk("R2 ce2 held high", int'(ce2), 1);
    endtask

    task automatic t_write(input logic [17:0] a, input logic [7:0] d, input int exp_busy, input string tag);
        run_u0(1'b1, a, d);
        chk({tag, " write busy"}, busy, exp_busy);
        chk("R4 we_n low cycles", we_lo, F_WE);
        chk("R4 data drive span", drv, F_WE + 2);
        chk("R4 select span", ce_lo, F_WE + 2);
        chk("R4 oe_n high in write", oe_lo, 0);
    endtask

    task automatic t_read(input logic [17:0] a, input logic [7:0] exp);
        run_u0(1'b0, a, 8'h00);
        chk("R3 read busy", busy, F_RD);
        chk("R3 oe_n low cycles", oe_lo, F_RD);
        chk("R3 we_n high in read", we_lo, 0);
        chk("R3 rsp_valid after read", int'(got_v), 1);
        chk("R3 read data", int'(got), int'(exp));
    endtask

    task automatic t_patterns;
        t_write(18'h00000, 8'hA5, F_WBSY, "R6");
        t_write(18'h3FFFF, 8'h5A, F_WBSY, "R6");
        t_write(18'h12345, 8'hFF, F_WBSY, "R6");
        t_write(18'h00080, 8'h00, F_WBSY, "R6");
        t_read(18'h00000, 8'hA5);
        t_read(18'h3FFFF, 8'h5A);
        t_read(18'h12345, 8'hFF);
        t_read(18'h00080, 8'h00);
    endtask

    task automatic t_turnaround;
        t_read(18'h3FFFF, 8'h5A);
        t_write(18'h00011, 8'h3C, F_WBSY + F_TURN, "R7");
        t_write(18'h00012, 8'hC3, F_WBSY, "R7");
        t_read(18'h00011, 8'h3C);
        t_read(18'h00012, 8'hC3);
    endtask

    task automatic t_handshake;
        // valid held while busy: second request accepted only after idle
        @(negedge clk);
        while (!rdy) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00011;
        @(negedge clk);
        req_addr = 18'h00012;
        busy = 0;
        while (!rdy && busy < 1000) begin busy++; @(negedge clk); end
        chk("R8 ready low while busy", busy, F_RD);
        chk("R8 first data", int'(rdata), 8'h3C);
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0;
        while (!rdy && busy < 1000) begin busy++; @(negedge clk); end
        chk("R8 second accepted at idle", busy, F_RD);
        chk("R8 second data", int'(rdata), 8'hC3);
    endtask

    task automatic t_slow;
        int b, w, o;
        @(negedge clk);
        s_valid = 1'b1; s_write = 1'b1; s_addr_req = 18'h00055; s_wdata = 8'h99;
        @(negedge clk);
        s_valid = 1'b0;
        b = 0; w = 0;
        while (!s_rdy && b < 1000) begin b++; if (!s_we_n) w++; @(negedge clk); end
        chk("R9 slow write busy", b, S_WBSY);
        chk("R9 slow we_n low", w, S_WE);
        s_valid = 1'b1; s_write = 1'b0;
        @(negedge clk);
        s_valid = 1'b0;
        b = 0; o = 0;
        while (!s_rdy && b < 1000) begin b++; if (!s_oe_n) o++; @(negedge clk); end
        chk("R9 slow read strobe", o, S_RD);
        chk("R9 slow read data", int'(s_rdata), 8'h3C);
        chk("R9 slow rsp_valid", int'(s_rv), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_standby;
        t_patterns;
        t_turnaround;
        t_handshake;
        t_slow;
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * T);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule